// File: doc/BRIEF.md
# Masked Event Latch Interrupt Controller

This block gathers five single-cycle event strobes into a set of pending bits and gates them with an enable mask. It drives one interrupt request to a host processor at a fixed priority level. The event sources are the external pin, the sample timer, the tempo timer, the asynchronous serial unit and the synchronous serial unit. An event whose mask bit is off when it arrives is discarded and leaves no trace.

Software reaches the block through one 16-bit register with two byte lanes. Writing the low lane loads the enable mask. Writing the high lane acknowledges interrupts: each one bit clears the matching pending bit. The two lanes may be written together or one at a time. A read of the register returns the pending bits rather than the mask. Once raised, the request stays up until software has cleared every pending bit that is still enabled.

Top module: `irqc_latch_ctrl`

## Requirements
- R1: After a synchronous reset, the mask and pending bits are all zero, `bus_rdata` reads 0x0000, `irq_req` is low and `irq_level` is 0.
- R2: Event input bit i maps to pending and mask bit i: bit 0 external, bit 1 sample timer, bit 2 tempo timer, bit 3 asynchronous serial, bit 4 synchronous serial.
- R3: A write with `bus_be[0]` set loads `bus_wdata[4:0]` into the mask from the next cycle on. Bits 7:5 of the low lane are ignored.
- R4: A write with `bus_be[1]` set clears every pending bit i for which `bus_wdata[8+i]` is 1. Pending bits whose clear bit is 0 are left unchanged.
- R5: `bus_rdata[4:0]` always shows the pending bits, and `bus_rdata[15:5]` reads zero.
- R6: An event on a source whose mask bit is 0 in that cycle does not set its pending bit.
- R7: An event on a source whose mask bit is 1 sets its pending bit in the next cycle. `irq_req` is high exactly when some bit is both pending and enabled, and it stays high until such bits are cleared or masked.
- R8: `irq_level` equals the parameter IRQ_LEVEL (default 2) while `irq_req` is high, and 0 otherwise.
- R9: Each byte lane acts alone. A write of only the high lane leaves the mask unchanged, and a write of only the low lane leaves the pending bits unchanged.
- R10: If an enabled event and a clear for the same bit arrive in the same cycle, the event wins and the bit stays pending.
- R11: Clearing a mask bit does not clear its pending bit. The request drops, and it returns when the mask bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_be | input | 2 | Byte lane enables: bit 1 is the clear lane, bit 0 is the mask lane |
| bus_wdata | input | 16 | Write data |
| evt_in | input | 5 | Single-cycle event strobes, one per source |
| bus_rdata | output | 16 | Pending bits, zero-extended |
| irq_req | output | 1 | Host interrupt request |
| irq_level | output | 3 | Priority level presented with the request |

## Verification
The assertions assume that `bus_be` is only meaningful when `bus_we` is high. They also assume that event strobes arrive synchronously with `clk`, and that an event strobe is a request for one cycle, so that a strobe held high simply re-arms its bit. The stimulus meets these conditions. It drives every input once per cycle, just after the falling edge, and it lowers `bus_we`, `bus_be` and `evt_in` between operations. The request-hold property relies on the request being released only through a register write. For that reason, the bench never changes the mask or the clear lane except through `bus_we`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int SRC_COUNT = 5;
    localparam int BUS_W     = 16;
    localparam int LANE_W    = 8;
    localparam int LANES     = BUS_W / LANE_W;

    typedef enum int {
        SRC_EXTERNAL = 0,
        SRC_SAMPLE   = 1,
        SRC_TEMPO    = 2,
        SRC_ASYNC    = 3,
        SRC_SYNC     = 4
    } src_e;

    typedef logic [SRC_COUNT-1:0] src_vec_t;

    typedef struct packed {
        logic     mask_load;
        src_vec_t mask_value;
        src_vec_t clear_bits;
    } bus_cmd_t;

    function automatic src_vec_t lane_bits(input logic [LANE_W-1:0] lane);
        return lane[SRC_COUNT-1:0];
    endfunction

endpackage

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode
    import irqc_pkg::*;
(
    input  logic                bus_we,
    input  logic [LANES-1:0]    bus_be,
    input  logic [BUS_W-1:0]    bus_wdata,
    output bus_cmd_t            cmd
);
    localparam int MASK_LANE  = 0;
    localparam int CLEAR_LANE = 1;

    logic [LANE_W-1:0] lane_data [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_data[g] = bus_wdata[g*LANE_W +: LANE_W];
    end

    always_comb begin
        cmd            = '0;
        cmd.mask_load  = bus_we && bus_be[MASK_LANE];
        cmd.mask_value = lane_bits(lane_data[MASK_LANE]);
        if (bus_we && bus_be[CLEAR_LANE])
            cmd.clear_bits = lane_bits(lane_data[CLEAR_LANE]);
    end

endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_cmd_t cmd,
    output src_vec_t mask_q
);
    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (cmd.mask_load)
            mask_q <= cmd.mask_value;
    end

endmodule

// File: rtl/irqc_pend_cell.sv
module irqc_pend_cell (
    input  logic clk,
    input  logic rst,
    input  logic event_i,
    input  logic enable_i,
    input  logic clear_i,
    output logic pend_o
);
    logic arm;

    assign arm = event_i && enable_i;

    always_ff @(posedge clk) begin
        if (rst)
            pend_o <= 1'b0;
        else if (arm)
            pend_o <= 1'b1;
        else if (clear_i)
            pend_o <= 1'b0;
    end

endmodule

// File: rtl/irqc_latch_ctrl.sv
module irqc_latch_ctrl
    import irqc_pkg::*;
#(
    parameter int LVL_W     = 3,
    parameter int IRQ_LEVEL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    input  logic [4:0]        evt_in,
    output logic [15:0]       bus_rdata,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level
);
    localparam int PAD_W = BUS_W - SRC_COUNT;

    bus_cmd_t cmd;
    src_vec_t mask_q;
    src_vec_t pend_q;
    src_vec_t live;

    irqc_bus_decode u_dec (
        .bus_we    (bus_we),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .cmd       (cmd)
    );

    irqc_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .mask_q (mask_q)
    );

    for (genvar s = 0; s < SRC_COUNT; s++) begin : g_src
        irqc_pend_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .event_i  (evt_in[s]),
            .enable_i (mask_q[s]),
            .clear_i  (cmd.clear_bits[s]),
            .pend_o   (pend_q[s])
        );
    end

    assign live      = pend_q & mask_q;
    assign irq_req   = |live;
    assign irq_level = irq_req ? LVL_W'(IRQ_LEVEL) : '0;
    assign bus_rdata = {{PAD_W{1'b0}}, pend_q};

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int LVL_W     = 3,
    parameter int IRQ_LEVEL = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [1:0]       bus_be,
    input logic [15:0]      bus_wdata,
    input logic [4:0]       evt_in,
    input logic [15:0]      bus_rdata,
    input logic             irq_req,
    input logic [LVL_W-1:0] irq_level,
    input logic [4:0]       mask_q,
    input logic [4:0]       pend_q
);
    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (mask_q == 5'd0 && pend_q == 5'd0 && !irq_req)); // R1

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_be[0]) |=> (mask_q == $past(bus_wdata[4:0]))); // R3

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_be[0]) |=> $stable(mask_q)); // R9

    AST_READ_PAD: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[15:5] == 11'd0 && bus_rdata[4:0] == pend_q); // R5

    AST_LEVEL_UP: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_level == LVL_W'(IRQ_LEVEL)); // R8

    AST_LEVEL_DOWN: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> irq_level == '0); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !bus_we) |=> irq_req); // R7

    for (genvar i = 0; i < 5; i++) begin : g_bit
        AST_DROP_MASKED: assert property (@(posedge clk) disable iff (rst)
            (!mask_q[i] && !pend_q[i]) |=> !pend_q[i]); // R6

        AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
            (evt_in[i] && mask_q[i]) |=> pend_q[i]); // R10

        AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_be[1] && bus_wdata[8+i] && !evt_in[i]) |=> !pend_q[i]); // R4
    end

endmodule

bind irqc_latch_ctrl irqc_chk #(.LVL_W(LVL_W), .IRQ_LEVEL(IRQ_LEVEL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .evt_in    (evt_in),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .mask_q    (mask_q),
    .pend_q    (pend_q)
);

// File: tb/sim_irqc_latch_ctrl.sv
`timescale 1ns/1ps
module sim_irqc_latch_ctrl;

    typedef struct {
        logic [15:0] rdata;
        logic        irq;
        logic [2:0]  lvl;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic [4:0]  evt_in = 5'h0;
    logic [15:0] bus_rdata;
    logic        irq_req;
    logic [2:0]  irq_level;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    logic [4:0]  m_mask = 5'h0;
    logic [4:0]  m_pend = 5'h0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irqc_latch_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .evt_in    (evt_in),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    task automatic push_expected(input string tag);
        exp_t e;
        e.rdata = {11'd0, m_pend};
        e.irq   = |(m_pend & m_mask);
        e.lvl   = e.irq ? 3'd2 : 3'd0;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    task automatic step(input logic we, input logic [1:0] be, input logic [15:0] wd,
                        input logic [4:0] ev, input string tag);
        logic [4:0] clr;
        @(negedge clk);
        bus_we = we; bus_be = be; bus_wdata = wd; evt_in = ev;
        @(posedge clk);
        #1;
        clr    = (we && be[1]) ? wd[12:8] : 5'h0;
        m_pend = (m_pend & ~clr) | (ev & m_mask);
        if (we && be[0]) m_mask = wd[4:0];
        bus_we = 1'b0; bus_be = 2'b00; bus_wdata = 16'h0; evt_in = 5'h0;
        push_expected(tag);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (bus_rdata !== e.rdata || irq_req !== e.irq || irq_level !== e.lvl) begin
                    n_fails++;
                    $display("FAIL %s: rdata=%h irq=%b lvl=%0d expected rdata=%h irq=%b lvl=%0d",
                             e.tag, bus_rdata, irq_req, irq_level, e.rdata, e.irq, e.lvl);
                end
            end
        end
    end

    initial begin : watchdog
        #(5.0 * 20000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_mask = 5'h0; m_pend = 5'h0;
        push_expected("R1 reset state");

        step(1'b1, 2'b01, 16'h001F, 5'h00, "R3 mask load all");
        step(1'b0, 2'b00, 16'h0000, 5'h02, "R2 R7 sample timer event");
        step(1'b0, 2'b00, 16'h0000, 5'h00, "R7 request holds");
        step(1'b1, 2'b01, 16'hFF00, 5'h00, "R9 R11 mask-only write keeps pending");
        step(1'b0, 2'b00, 16'h0000, 5'h08, "R6 masked async event dropped");
        step(1'b1, 2'b01, 16'h001F, 5'h00, "R11 re-enable restores request");
        step(1'b0, 2'b00, 16'h0000, 5'h15, "R7 three events");
        step(1'b1, 2'b10, 16'h0500, 5'h00, "R4 R9 clear-lane write");
        step(1'b1, 2'b11, 16'h1210, 5'h00, "R4 R3 full word write");
        step(1'b1, 2'b10, 16'h1000, 5'h10, "R10 event beats clear");
        step(1'b1, 2'b10, 16'h1000, 5'h00, "R4 clear after win");
        step(1'b1, 2'b01, 16'h00FF, 5'h00, "R3 upper low-lane bits ignored");
        step(1'b0, 2'b00, 16'h0000, 5'h1F, "R5 all sources pending");
        step(1'b1, 2'b10, 16'h1F00, 5'h00, "R4 clear all");
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 2'b00, 16'h0000, 5'(1 << i), "R2 single source bit");
            step(1'b1, 2'b10, 16'(1 << (8 + i)), 5'h00, "R4 single bit clear");
        end
        step(1'b1, 2'b01, 16'h0004, 5'h01, "R6 event uses old mask on mask write");
        step(1'b0, 2'b00, 16'h0000, 5'h01, "R6 external now masked");
        step(1'b0, 2'b00, 16'h0000, 5'h04, "R8 tempo level");

        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_mask = 5'h0; m_pend = 5'h0;
        push_expected("R1 reset clears state");
        step(1'b0, 2'b00, 16'h0000, 5'h1F, "R1 R6 mask zero after reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule